// File: doc/BRIEF.md
# Privileged Interrupt Mask Arbiter

This block keeps the pending and enable bit vectors for nine interrupt sources: software, timer and external at each of three privilege levels (user, supervisor, machine). From the current privilege level, the three global enable bits of the status register and the two delegation vectors, it forms a per-source global mask. A source whose pending, enable and mask bits are all set is a candidate. The block raises a take flag when any candidate exists and reports the cause number of the candidate that wins a fixed priority scan.

Pending bits are set and cleared by single-source strobes. A clear-all strobe wipes the whole pending vector. Both vectors can be read at any time and overwritten as whole words. The decision logic is purely combinational from the registered vectors and the level, status and delegation inputs. A core samples `irq_take` and `irq_cause` at instruction boundaries; trap entry itself happens outside this block.

Top module: `priv_irq_arbiter`

## Requirements
- R1: After reset, the pending and enable vectors read as zero, `irq_take` is 0 and `irq_cause` is 0.
- R2: Source bit positions are: user software 0, supervisor software 1, machine software 3, user timer 4, supervisor timer 5, machine timer 7, user external 8, supervisor external 9, machine external 11. A source is a candidate when its pending, enable and global-mask bits are all 1. `irq_take` is the OR over all candidates.
- R3: At level 0 (user), each machine and supervisor source passes the mask when its bit in `sdeleg` is 0, or when `st_uie` is 1. The user sources pass only when `st_uie` is 1.
- R4: At level 1 (supervisor), each machine source passes when its bit in `mdeleg` is 0, or when `st_sie` is 1. Supervisor sources pass only when `st_sie` is 1. User sources never pass.
- R5: At level 3 (machine), machine sources pass only when `st_mie` is 1, and no other source passes. Level 2 masks every source.
- R6: A `post_vld` strobe sets pending bit `post_id` and a `clr_vld` strobe clears pending bit `clr_id`, both from the next clock. When both strobes name the same bit, the post wins. Strobes that name a position with no source have no effect.
- R7: `clr_all` zeroes the pending vector on the next clock and leaves the enable vector unchanged. A post in the same cycle still sets its bit.
- R8: `pend_we` and `en_we` overwrite their vector with the write data on the next clock. Positions with no source always read 0. Within a cycle, `clr_all`, post and clear strobes are applied after, and override, a pending-vector write.
- R9: The winning candidate is the first found in the order 11, 3, 7, 9, 1, 5, 8, 0, 4. `irq_cause` is its bit position. With no candidate, `irq_cause` is 0 and `irq_take` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| post_vld | input | 1 | Set one pending bit |
| post_id | input | IDW | Bit position to set |
| clr_vld | input | 1 | Clear one pending bit |
| clr_id | input | IDW | Bit position to clear |
| clr_all | input | 1 | Zero the pending vector |
| pend_we | input | 1 | Whole-word pending write |
| pend_wdata | input | W | Pending write data |
| en_we | input | 1 | Whole-word enable write |
| en_wdata | input | W | Enable write data |
| pend_rdata | output | W | Current pending vector |
| en_rdata | output | W | Current enable vector |
| priv | input | 2 | Privilege level: 0 user, 1 supervisor, 3 machine, 2 unsupported |
| st_uie | input | 1 | User global enable |
| st_sie | input | 1 | Supervisor global enable |
| st_mie | input | 1 | Machine global enable |
| mdeleg | input | W | Machine-level delegation vector |
| sdeleg | input | W | Supervisor-level delegation vector |
| irq_take | output | 1 | Some candidate exists |
| irq_cause | output | IDW | Bit position of the winning candidate |

## Verification
The bench targets several corner cases, each tied to a specific wrong design:
- A machine source that is delegated while at a lower level must still fire when its level's enable is clear and it is not delegated. A design that applied the level's own enable to every source would hold it off.
- Level 2 must stop everything. A decoder that treated 2 like machine mode would let machine sources through.
- A post, a clear and a whole-word write in the same cycle test the merge order. A design that let the write win would drop the strobe.
- The priority interleave (machine software above machine timer, user software above user timer) is tested with several pending sources at once. A plain highest-bit-first encoder would report the wrong cause.

// File: rtl/priv_irq_arbiter.sv
module priv_irq_arbiter #(
  parameter int W   = 12,
  parameter int IDW = 4
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           post_vld,
  input  logic [IDW-1:0] post_id,
  input  logic           clr_vld,
  input  logic [IDW-1:0] clr_id,
  input  logic           clr_all,
  input  logic           pend_we,
  input  logic [W-1:0]   pend_wdata,
  input  logic           en_we,
  input  logic [W-1:0]   en_wdata,
  output logic [W-1:0]   pend_rdata,
  output logic [W-1:0]   en_rdata,
  input  logic [1:0]     priv,
  input  logic           st_uie,
  input  logic           st_sie,
  input  logic           st_mie,
  input  logic [W-1:0]   mdeleg,
  input  logic [W-1:0]   sdeleg,
  output logic           irq_take,
  output logic [IDW-1:0] irq_cause
);
  localparam logic [W-1:0] M_SET = W'(12'h888);
  localparam logic [W-1:0] S_SET = W'(12'h222);
  localparam logic [W-1:0] U_SET = W'(12'h111);
  localparam logic [W-1:0] IMPL  = M_SET | S_SET | U_SET;
  localparam int NSRC = 9;
  localparam int ORDER [NSRC] = '{11, 3, 7, 9, 1, 5, 8, 0, 4};

  logic [W-1:0] pend_q, en_q, pend_d, gmask, cand;
  logic [W-1:0] post_vec, clr_vec;

  assign post_vec = post_vld ? ((W'(1) << post_id) & IMPL) : '0;
  assign clr_vec  = clr_vld  ? ((W'(1) << clr_id)  & IMPL) : '0;

  always_comb begin
    pend_d = pend_we ? (pend_wdata & IMPL) : pend_q;
    if (clr_all) pend_d = '0;
    pend_d = (pend_d & ~clr_vec) | post_vec;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= '0;
      en_q   <= '0;
    end else begin
      pend_q <= pend_d;
      if (en_we) en_q <= en_wdata & IMPL;
    end
  end

  assign pend_rdata = pend_q;
  assign en_rdata   = en_q;

  always_comb begin
    case (priv)
      2'd0:    gmask = ((M_SET | S_SET) & (~sdeleg | {W{st_uie}})) | (U_SET & {W{st_uie}});
      2'd1:    gmask = (M_SET & (~mdeleg | {W{st_sie}})) | (S_SET & {W{st_sie}});
      2'd3:    gmask = M_SET & {W{st_mie}};
      default: gmask = '0;
    endcase
  end

  assign cand     = pend_q & en_q & gmask;
  assign irq_take = |cand;

  always_comb begin
    irq_cause = '0;
    for (int k = NSRC - 1; k >= 0; k--)
      if (cand[ORDER[k]]) irq_cause = IDW'(ORDER[k]);
  end
endmodule

module priv_irq_arbiter_chk #(
  parameter int W   = 12,
  parameter int IDW = 4
) (
  input logic           clk,
  input logic           rst_n,
  input logic           post_vld,
  input logic           clr_all,
  input logic           en_we,
  input logic [W-1:0]   pend_rdata,
  input logic [W-1:0]   en_rdata,
  input logic [1:0]     priv,
  input logic           irq_take,
  input logic [IDW-1:0] irq_cause
);
  logic cause_live;
  assign cause_live = |(((pend_rdata & en_rdata) >> irq_cause) & W'(1));

  assert_cause_live_R2: assert property (@(posedge clk) disable iff (!rst_n)
    irq_take |-> cause_live);
  assert_none_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ((pend_rdata & en_rdata) == '0) |-> (!irq_take && irq_cause == '0));
  assert_super_no_user_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (priv == 2'd1 && irq_take) |-> (irq_cause != 0 && irq_cause != 4 && irq_cause != 8));
  assert_machine_only_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (priv == 2'd3 && irq_take) |-> (irq_cause == 3 || irq_cause == 7 || irq_cause == 11));
  assert_level2_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (priv == 2'd2) |-> !irq_take);
  assert_clear_all_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_all && !post_vld) |=> (pend_rdata == '0));
  assert_enable_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !en_we |=> (en_rdata == $past(en_rdata)));
endmodule

bind priv_irq_arbiter priv_irq_arbiter_chk #(.W(W), .IDW(IDW)) u_chk (
  .clk(clk), .rst_n(rst_n), .post_vld(post_vld), .clr_all(clr_all), .en_we(en_we),
  .pend_rdata(pend_rdata), .en_rdata(en_rdata), .priv(priv),
  .irq_take(irq_take), .irq_cause(irq_cause)
);

// File: tb/priv_irq_arbiter_test.sv
`timescale 1ns/1ps
module priv_irq_arbiter_test;
  localparam int W = 12;
  localparam int IDW = 4;
  localparam logic [W-1:0] IMPL = 12'hBBB;

  logic clk = 0, rst_n = 0;
  logic post_vld = 0, clr_vld = 0, clr_all = 0, pend_we = 0, en_we = 0;
  logic [IDW-1:0] post_id = 0, clr_id = 0;
  logic [W-1:0] pend_wdata = 0, en_wdata = 0, mdeleg = 0, sdeleg = 0;
  logic [1:0] priv = 2'd3;
  logic st_uie = 0, st_sie = 0, st_mie = 0;
  logic [W-1:0] pend_rdata, en_rdata;
  logic irq_take;
  logic [IDW-1:0] irq_cause;

  int tests = 0, fails = 0;
  logic [W-1:0] m_pend = 0, m_en = 0;

  always #4 clk = ~clk;

  priv_irq_arbiter #(.W(W), .IDW(IDW)) uut (.*);

  function automatic logic [W-1:0] f_mask();
    logic [W-1:0] m = 0;
    for (int b = 0; b < W; b++) begin
      if (!IMPL[b]) continue;
      case (priv)
        2'd0: m[b] = (b % 4 == 0) ? st_uie : (!sdeleg[b] || st_uie);
        2'd1: m[b] = (b % 4 == 0) ? 1'b0 : (b % 4 == 1) ? st_sie : (!mdeleg[b] || st_sie);
        2'd3: m[b] = (b % 4 == 3) ? st_mie : 1'b0;
        default: m[b] = 1'b0;
      endcase
    end
    return m;
  endfunction

  function automatic int f_cause(logic [W-1:0] c);
    int ord [9] = '{11, 3, 7, 9, 1, 5, 8, 0, 4};
    for (int k = 0; k < 9; k++) if (c[ord[k]]) return ord[k];
    return 0;
  endfunction

  task automatic check(string tag, logic cond, string what, int act, int exp);
    tests++;
    if (!cond) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic compare(string tag);
    logic [W-1:0] c = m_pend & m_en & f_mask();
    check(tag, pend_rdata == m_pend, "pending", pend_rdata, m_pend);
    check(tag, en_rdata == m_en, "enable", en_rdata, m_en);
    check(tag, irq_take == (c != 0), "take", irq_take, c != 0);
    check(tag, irq_cause == IDW'(f_cause(c)), "cause", irq_cause, f_cause(c));
  endtask

  task automatic cyc(string tag);
    logic [W-1:0] np;
    np = pend_we ? (pend_wdata & IMPL) : m_pend;
    if (clr_all) np = 0;
    if (clr_vld && clr_id < W && IMPL[clr_id]) np[clr_id] = 0;
    if (post_vld && post_id < W && IMPL[post_id]) np[post_id] = 1;
    @(posedge clk);
    m_pend = np;
    if (en_we) m_en = en_wdata & IMPL;
    #2;
    compare(tag);
    @(negedge clk);
    post_vld = 0; clr_vld = 0; clr_all = 0; pend_we = 0; en_we = 0;
  endtask

  task automatic load(logic [W-1:0] p, logic [W-1:0] e);
    pend_we = 1; pend_wdata = p; en_we = 1; en_wdata = e;
    cyc("R8");
  endtask

  initial begin
    #(8 * 200000);
    fails++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    #10;
    check("R1", pend_rdata == 0 && en_rdata == 0, "reset vectors", pend_rdata, 0);
    check("R1", !irq_take && irq_cause == 0, "reset outputs", irq_cause, 0);
    @(negedge clk); rst_n = 1;

    // R3: delegated machine timer at user level
    priv = 0; st_uie = 0; sdeleg = 12'h080;
    load(12'h080, 12'h080);
    check("R3", !irq_take, "delegated masked", irq_take, 0);
    sdeleg = 0; #1;
    check("R3", irq_take && irq_cause == 7, "undelegated passes", irq_cause, 7);
    load(12'h001, 12'h001);
    check("R3", !irq_take, "user sw needs uie", irq_take, 0);
    st_uie = 1; #1;
    check("R3", irq_take && irq_cause == 0, "user sw with uie", irq_cause, 0);

    // R4: supervisor level
    priv = 1; st_sie = 0; mdeleg = 0;
    load(12'h111 | 12'h008, 12'hFFF);
    check("R4", irq_take && irq_cause == 3, "machine sw undelegated", irq_cause, 3);
    mdeleg = 12'h008; #1;
    check("R4", !irq_take, "delegated msw needs sie, user masked", irq_take, 0);

    // R5: machine level and level 2
    priv = 3; st_mie = 0;
    load(12'hBBB, 12'hBBB);
    check("R5", !irq_take, "mie clear", irq_take, 0);
    st_mie = 1; #1;
    check("R9", irq_take && irq_cause == 11, "top priority", irq_cause, 11);
    priv = 2; #1;
    check("R5", !irq_take, "level 2 masks all", irq_take, 0);

    // R9: interleaved priority
    priv = 3;
    load(12'h088, 12'hFFF);
    check("R9", irq_cause == 3, "msw over mti", irq_cause, 3);
    priv = 0; st_uie = 1; sdeleg = 12'hFFF;
    load(12'h011, 12'hFFF);
    check("R9", irq_cause == 0, "usw over uti", irq_cause, 0);

    // R6/R8: strobe merge against write
    pend_we = 1; pend_wdata = 12'h000; post_vld = 1; post_id = 5; clr_vld = 1; clr_id = 5;
    cyc("R6");
    check("R6", pend_rdata == 12'h020, "post wins over clear and write", pend_rdata, 12'h020);
    post_vld = 1; post_id = 2; cyc("R6");
    check("R6", pend_rdata == 12'h020, "unimplemented post ignored", pend_rdata, 12'h020);
    pend_we = 1; pend_wdata = 12'hFFF; clr_vld = 1; clr_id = 11; cyc("R8");
    check("R8", pend_rdata == 12'h3BB, "clear over write", pend_rdata, 12'h3BB);

    // R7
    clr_all = 1; post_vld = 1; post_id = 9; cyc("R7");
    check("R7", pend_rdata == 12'h200 && en_rdata == 12'hBBB, "clear all", pend_rdata, 12'h200);

    // random
    for (int i = 0; i < 3000; i++) begin
      post_vld = ($urandom % 3) == 0; post_id = IDW'($urandom);
      clr_vld = ($urandom % 3) == 0; clr_id = IDW'($urandom);
      clr_all = ($urandom % 20) == 0;
      pend_we = ($urandom % 8) == 0; pend_wdata = W'($urandom);
      en_we = ($urandom % 8) == 0; en_wdata = W'($urandom);
      priv = 2'($urandom);
      st_uie = 1'($urandom); st_sie = 1'($urandom); st_mie = 1'($urandom);
      mdeleg = W'($urandom); sdeleg = W'($urandom);
      cyc("R2");
    end

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
  end
endmodule